// File: doc/BRIEF.md
# Banked Translation-Table Register Port

This block is the register-level access path that software uses to fill and inspect two address-translation tables. Each table has 4 sets of 16 entries, and every entry is a pair of 32-bit words: a tag-side "hi" word and a data-side "lo" word. Software talks to the block through a bank of 32-bit support registers. A 2-bit bank selector decides which of four register banks the accesses reach. Banks 1 and 2 are wired to table 0 and table 1. Banks 0 and 3 are plain storage only.

Inside a table bank, four register numbers have extra meaning. The selector register names the set and the entry. Writing the hi register also copies the value into the cause register. Writing the lo register commits an entry built from the cause register and the new lo value. Every read first reloads the hi and lo registers from the selected table entry, and then returns the register that was asked for. A read answers one cycle after the request. A two-state response machine marks that cycle. In RSP_IDLE no data is valid. RSP_IDLE goes to RSP_SEND on a read request. RSP_SEND stays in RSP_SEND on a back-to-back request and returns to RSP_IDLE when no request is present.

Top module: `banked_tlb_port`

## Requirements
- R1: Reset clears the following: the bank selector (cur_bank reads 0), every support register in every bank, and every table entry. After reset rd_valid is low.
- R2: A bank_we pulse loads the bank selector with bank_wdata[1:0], and bits 31:2 have no effect. The new bank shows on cur_bank from the next cycle. Register accesses made in the same cycle as bank_we use the old bank.
- R3: A read requested with rd_en is answered in the next cycle, with rd_valid high and rd_data holding the value. In a cycle with no request, rd_valid is low and rd_data keeps its last value.
- R4: Each bank holds its own 16 registers of 32 bits. A register number that has no special meaning reads back the last value written to it in that bank.
- R5: The selector register (default number 4) addresses a table entry. Bits [5:4] give the set and bits [3:0] give the entry.
- R6: In banks 1 and 2, a write to the hi register (default number 5) also writes the same value into that bank's cause register (default number 7).
- R7: In banks 1 and 2, a write to the lo register (default number 6) stores an entry into table (bank−1), at the selected set and entry. The entry takes the hi word from that bank's current cause register and the lo word from the written data.
- R8: In banks 1 and 2, a read first loads the hi and lo registers from the selected entry. A read of hi or lo therefore returns the stored entry words.
- R9: In banks 0 and 3, the hi, lo and cause registers are plain storage. There is no cause side effect, no table commit and no reload.
- R10: A read in the same cycle as a write returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Load the bank selector |
| bank_wdata | input | 32 | Bank selector value; only bits 1:0 are kept |
| wr_en | input | 1 | Support register write strobe |
| wr_addr | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Register number to read |
| cur_bank | output | 2 | Current bank selector |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |

## Verification
The assertions check on every cycle that a read response follows its request by exactly one cycle and that rd_data holds between reads. They also check that the bank selector keeps only its low bits and changes only on bank_we. Two roundtrips are checked the same way: a hi write followed by a cause read, and a lo write followed by a lo read, each within a table bank. Several behaviours can only be shown by the bench scenarios, because they depend on long histories: set and entry decoding, separation of the two tables, the cause-sourced hi word of a commit, the absence of side effects in banks 0 and 3, and the ordering of same-cycle reads and writes.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    localparam int WORD_W = 32;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } tlb_word_t;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_SEND = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlbp_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  tlb_word_t        wword,
    input  logic [IDX_W-1:0] ridx,
    output tlb_word_t        rword
);

    tlb_word_t mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[widx] <= wword;
        end
    end

    assign rword = mem_q[ridx];

endmodule

// File: rtl/bank_reg_file.sv
module bank_reg_file
    import tlbp_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_REGS  = 16,
    parameter int BANK_W    = 2,
    parameter int REG_AW    = 4,
    parameter int REG_SEL   = 4,
    parameter int REG_HI    = 5,
    parameter int REG_LO    = 6,
    parameter int REG_CAUSE = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              cause_we,
    input  logic              refresh_we,
    input  logic [WORD_W-1:0] refresh_hi,
    input  logic [WORD_W-1:0] refresh_lo,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] sel_word,
    output logic [WORD_W-1:0] cause_word
);

    logic [WORD_W-1:0] regs_q [NUM_BANKS][NUM_REGS];

    // Priority per register: direct write, then cause side copy, then reload.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int r = 0; r < NUM_REGS; r++) begin
                    regs_q[b][r] <= '0;
                end
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int r = 0; r < NUM_REGS; r++) begin
                    if (bank == BANK_W'(b)) begin
                        if (wr_en && wr_addr == REG_AW'(r)) begin
                            regs_q[b][r] <= wr_data;
                        end else if (cause_we && r == REG_CAUSE) begin
                            regs_q[b][r] <= wr_data;
                        end else if (refresh_we && r == REG_HI) begin
                            regs_q[b][r] <= refresh_hi;
                        end else if (refresh_we && r == REG_LO) begin
                            regs_q[b][r] <= refresh_lo;
                        end
                    end
                end
            end
        end
    end

    assign rd_word    = regs_q[bank][rd_addr];
    assign sel_word   = regs_q[bank][REG_SEL];
    assign cause_word = regs_q[bank][REG_CAUSE];

endmodule

// File: rtl/banked_tlb_port.sv
module banked_tlb_port
    import tlbp_pkg::*;
#(
    parameter int NUM_MMU     = 2,
    parameter int NUM_SETS    = 4,
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_REGS    = 16,
    parameter int REG_SEL     = 4,
    parameter int REG_HI      = 5,
    parameter int REG_LO      = 6,
    parameter int REG_CAUSE   = 7,
    localparam int REG_AW     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [31:0]       bank_wdata,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [1:0]        cur_bank,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int ENT_W     = $clog2(NUM_ENTRIES);
    localparam int SET_W     = $clog2(NUM_SETS);
    localparam int MMU_W     = (NUM_MMU > 1) ? $clog2(NUM_MMU) : 1;
    localparam int DEPTH     = NUM_MMU * NUM_SETS * NUM_ENTRIES;
    localparam int TIDX_W    = $clog2(DEPTH);

    logic [BANK_W-1:0] bank_q;
    logic              mmu_sel;
    logic [MMU_W-1:0]  mmu_idx;
    logic [SET_W-1:0]  set_f;
    logic [ENT_W-1:0]  ent_f;
    logic [TIDX_W-1:0] tidx;
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] cause_word;
    logic [WORD_W-1:0] reg_rd_word;
    logic [WORD_W-1:0] rd_mux;
    logic              tbl_we;
    logic              cause_we;
    logic              refresh_we;
    tlb_word_t         tbl_rword;
    tlb_word_t         tbl_wword;
    rsp_state_e        rsp_q;
    rsp_state_e        rsp_d;
    logic              unused_bits;

    assign unused_bits = ^{bank_wdata[31:BANK_W], sel_word[WORD_W-1:SET_W+ENT_W]};

    // Bank selector: only the low bits are kept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (bank_we) begin
            bank_q <= bank_wdata[BANK_W-1:0];
        end
    end

    assign cur_bank = bank_q;
    assign mmu_sel  = (int'(bank_q) >= 1) && (int'(bank_q) <= NUM_MMU);
    assign mmu_idx  = MMU_W'(bank_q - BANK_W'(1));
    assign set_f    = sel_word[ENT_W +: SET_W];
    assign ent_f    = sel_word[ENT_W-1:0];
    assign tidx     = TIDX_W'(mmu_idx) * TIDX_W'(NUM_SETS * NUM_ENTRIES)
                    + TIDX_W'(set_f) * TIDX_W'(NUM_ENTRIES)
                    + TIDX_W'(ent_f);

    assign tbl_we     = wr_en && mmu_sel && (wr_addr == REG_AW'(REG_LO));
    assign cause_we   = wr_en && mmu_sel && (wr_addr == REG_AW'(REG_HI));
    assign refresh_we = rd_en && mmu_sel;
    assign tbl_wword  = '{hi: cause_word, lo: wr_data};

    tlb_entry_store #(
        .DEPTH (DEPTH),
        .IDX_W (TIDX_W)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .widx  (tidx),
        .wword (tbl_wword),
        .ridx  (tidx),
        .rword (tbl_rword)
    );

    bank_reg_file #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_REGS  (NUM_REGS),
        .BANK_W    (BANK_W),
        .REG_AW    (REG_AW),
        .REG_SEL   (REG_SEL),
        .REG_HI    (REG_HI),
        .REG_LO    (REG_LO),
        .REG_CAUSE (REG_CAUSE)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank       (bank_q),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cause_we   (cause_we),
        .refresh_we (refresh_we),
        .refresh_hi (tbl_rword.hi),
        .refresh_lo (tbl_rword.lo),
        .rd_addr    (rd_addr),
        .rd_word    (reg_rd_word),
        .sel_word   (sel_word),
        .cause_word (cause_word)
    );

    // A table-bank read returns the freshly reloaded hi/lo words.
    always_comb begin
        rd_mux = reg_rd_word;
        if (mmu_sel && rd_addr == REG_AW'(REG_HI)) begin
            rd_mux = tbl_rword.hi;
        end else if (mmu_sel && rd_addr == REG_AW'(REG_LO)) begin
            rd_mux = tbl_rword.lo;
        end
    end

    // Response state machine.
    always_comb begin
        rsp_d = rsp_q;
        unique case (rsp_q)
            RSP_IDLE: if (rd_en) rsp_d = RSP_SEND;
            RSP_SEND: if (!rd_en) rsp_d = RSP_IDLE;
            default:  rsp_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= RSP_IDLE;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    // Output process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    assign rd_valid = (rsp_q == RSP_SEND);

endmodule

// File: rtl/tlb_port_checker.sv
module tlb_port_checker #(
    parameter int NUM_MMU   = 2,
    parameter int REG_AW    = 4,
    parameter int REG_HI    = 5,
    parameter int REG_LO    = 6,
    parameter int REG_CAUSE = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_we,
    input logic [31:0]       bank_wdata,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              rd_en,
    input logic [REG_AW-1:0] rd_addr,
    input logic [1:0]        cur_bank,
    input logic              rd_valid,
    input logic [31:0]       rd_data
);

    logic [1:0] age_q;
    logic       mmu_now;
    logic       unused_chk;

    assign unused_chk = ^bank_wdata[31:2];
    assign mmu_now    = (cur_bank != 2'd0) && (int'(cur_bank) <= NUM_MMU);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_valid_timing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_no_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && $stable(rd_data)));

    p_bank_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (cur_bank == $past(bank_wdata[1:0])));

    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_we |=> $stable(cur_bank));

    p_cause_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(wr_en && wr_addr == REG_AW'(REG_HI) && !bank_we)
         && mmu_now && rd_en && rd_addr == REG_AW'(REG_CAUSE) && !wr_en)
        |=> (rd_data == $past(wr_data, 2)));

    p_commit_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(wr_en && wr_addr == REG_AW'(REG_LO) && !bank_we)
         && mmu_now && rd_en && rd_addr == REG_AW'(REG_LO) && !wr_en)
        |=> (rd_data == $past(wr_data, 2)));

endmodule

bind banked_tlb_port tlb_port_checker #(
    .NUM_MMU   (NUM_MMU),
    .REG_AW    (REG_AW),
    .REG_HI    (REG_HI),
    .REG_LO    (REG_LO),
    .REG_CAUSE (REG_CAUSE)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_we    (bank_we),
    .bank_wdata (bank_wdata),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .cur_bank   (cur_bank),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
);

// File: tb/banked_tlb_port_tb_top.sv
`timescale 1ns/1ps
module banked_tlb_port_tb_top;

    localparam int SEL   = 4;
    localparam int HI    = 5;
    localparam int LO    = 6;
    localparam int CAUSE = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_we = 1'b0;
    logic [31:0] bank_wdata = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [1:0]  cur_bank;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    banked_tlb_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .cur_bank   (cur_bank),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic set_bank(input logic [31:0] v);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = v;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    task automatic wreg(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " R3 valid"}, 32'(rd_valid), 32'd1);
        chk(tag, rd_data, exp);
    endtask

    task automatic t_reset();
        chk("R1 bank after reset", 32'(cur_bank), 32'd0);
        chk("R1 valid after reset", 32'(rd_valid), 32'd0);
        rreg(2, 32'h0, "R1 bank0 reg cleared");
        set_bank(32'd1);
        rreg(LO, 32'h0, "R1 table cleared");
    endtask

    task automatic t_bank_mask();
        set_bank(32'hFFFF_FFF6);
        chk("R2 masked bank 2", 32'(cur_bank), 32'd2);
        set_bank(32'h0000_0105);
        chk("R2 masked bank 1", 32'(cur_bank), 32'd1);
    endtask

    task automatic t_plain();
        set_bank(32'd0);
        wreg(3, 32'hA0A0_0003);
        set_bank(32'd1);
        wreg(3, 32'hB1B1_0003);
        rreg(3, 32'hB1B1_0003, "R4 bank1 storage");
        set_bank(32'd0);
        rreg(3, 32'hA0A0_0003, "R4 bank0 storage");
    endtask

    task automatic t_timing();
        @(negedge clk);
        chk("R3 no request no valid", 32'(rd_valid), 32'd0);
        chk("R3 data held", rd_data, 32'hA0A0_0003);
    endtask

    task automatic t_cause_copy();
        set_bank(32'd1);
        wreg(HI, 32'h1234_5678);
        rreg(CAUSE, 32'h1234_5678, "R6 hi copied to cause");
    endtask

    task automatic t_commit();
        wreg(SEL, 32'h29);
        wreg(HI, 32'h1111_0029);
        wreg(CAUSE, 32'h2222_0029);
        wreg(LO, 32'h3333_0029);
        wreg(SEL, 32'h19);
        rreg(HI, 32'h0, "R5 other set hi");
        rreg(LO, 32'h0, "R5 other set lo");
        wreg(SEL, 32'h2A);
        rreg(LO, 32'h0, "R5 other entry lo");
        wreg(SEL, 32'h29);
        rreg(HI, 32'h2222_0029, "R7 hi from cause");
        rreg(LO, 32'h3333_0029, "R8 lo reloaded");
    endtask

    task automatic t_two_tables();
        set_bank(32'd2);
        wreg(SEL, 32'h29);
        rreg(HI, 32'h0, "R7 second table untouched");
        wreg(HI, 32'h4444_0002);
        wreg(LO, 32'h5555_0002);
        set_bank(32'd1);
        rreg(LO, 32'h3333_0029, "R7 first table kept");
        set_bank(32'd2);
        rreg(HI, 32'h4444_0002, "R8 second table hi");
    endtask

    task automatic t_plain_banks();
        set_bank(32'd0);
        wreg(SEL, 32'h29);
        wreg(CAUSE, 32'h7777_0000);
        wreg(HI, 32'h6666_0000);
        rreg(CAUSE, 32'h7777_0000, "R9 no cause copy");
        wreg(LO, 32'h8888_0000);
        rreg(HI, 32'h6666_0000, "R9 no reload hi");
        rreg(LO, 32'h8888_0000, "R9 no reload lo");
        set_bank(32'd3);
        wreg(SEL, 32'h29);
        wreg(HI, 32'h9999_0003);
        wreg(LO, 32'hAAAA_0003);
        rreg(HI, 32'h9999_0003, "R9 bank3 hi storage");
        set_bank(32'd1);
        rreg(LO, 32'h3333_0029, "R9 no commit lo");
        rreg(HI, 32'h2222_0029, "R9 no commit hi");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(LO); wr_data = 32'hABCD_0010;
        rd_en = 1'b1; rd_addr = 4'(CAUSE);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 read before write", rd_data, 32'h2222_0029);
        rreg(LO, 32'hABCD_0010, "R7 commit after overlap");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(LO); wr_data = 32'hDEAD_0011;
        rd_en = 1'b1; rd_addr = 4'(LO);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 old lo returned", rd_data, 32'hABCD_0010);
        rreg(LO, 32'hDEAD_0011, "R10 new lo later");
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = 32'd2;
        rd_en = 1'b1; rd_addr = 4'(HI);
        @(negedge clk);
        bank_we = 1'b0; rd_en = 1'b0;
        chk("R2 access uses old bank", rd_data, 32'h2222_0029);
        rreg(HI, 32'h4444_0002, "R2 new bank next cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank_mask();
        t_plain();
        t_timing();
        t_cause_copy();
        t_commit();
        t_two_tables();
        t_plain_banks();
        t_same_cycle();
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule